// File: doc/BRIEF.md
# Digital Potentiometer Command Executor

This block sits behind a serial-bus front end that has already recognised a start condition and a matching device address. It takes the bytes that follow and runs them as potentiometer commands. It keeps four channels. Each channel has one volatile wiper position and four 6-bit stored settings. A command can read or write a position or a stored setting. It can copy between the two, either for one channel or for all four channels at once. It can also put one channel into step mode, where the front end nudges the wiper up or down one tap per pulse.

Writes to stored settings model nonvolatile memory. Nothing happens when the command arrives. When the frame's stop condition arrives, the block raises `busy` for `BUSY_CYCLES` system clocks. The stored register takes its new value on the cycle `busy` falls. While `busy` is high, the block ignores new frames, so the front end can offer acknowledge polling by not acknowledging its address. A low `wp_n` pin blocks stored-register writes. Such a write is still acknowledged, but it changes nothing and starts no busy period.

Bytes arrive on a valid/ready stream. A byte is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only while a read result is waiting. Read results leave on a second valid/ready stream. Once `rd_valid` rises, it stays high with `rd_data` unchanged until a cycle where `rd_ready` is high. A stop or a new frame drops a read result that has not been taken. Each byte taken inside a frame is answered one cycle later by a single-cycle `ack_valid` pulse, with `ack_ok` giving acknowledge (1) or no acknowledge (0).

Top module: `pot_exec`

## Requirements
- R1: After reset, all sixteen stored registers hold `RESET_VAL` (default 0x20). Every position equals its channel's stored register 0, `busy` is 0, and no read result is pending.
- R2: A command byte carries the opcode in bits 7..4, the stored-register index in bits 3..2 and the channel in bits 1..0. Write position (opcode 1010) acknowledges both the command byte and the data byte. The position takes data bits 5..0 on the cycle the data byte is taken. Data bits 7..6 are ignored.
- R3: Read position (1001) and read stored register (1011) acknowledge the command byte and offer one result byte {2'b00, value} on the read stream. The result is held stable, with `in_ready` low, until `rd_ready` takes it.
- R4: Write stored register (1100) acknowledges both bytes. Only data bits 5..0 are kept. No register changes until the stop. From the cycle after the stop, `busy` stays high for exactly `BUSY_CYCLES` cycles, and the stored register changes when `busy` falls.
- R5: Copy stored to position (1101) loads the selected channel's position from its selected stored register on the cycle the command byte is taken. The following stop starts no busy period.
- R6: Copy position to stored (1110) captures the channel's position at the command byte. It then writes that value to the selected stored register through the same busy window as R4.
- R7: Global copy stored to position (0001) and global copy position to stored (1000) act on all four channels, using the one register index. Either opcode with channel bits other than 00 is not acknowledged and has no effect.
- R8: While `wp_n` is 0, commands 1100, 1110 and 1000 are acknowledged but change no stored register and start no busy period.
- R9: Any other opcode (for example 0000, 0011, 1111) is not acknowledged and changes no register. Every further byte of that frame is not acknowledged.
- R10: While `busy` is high, `frame_open` is ignored. Bytes then offered produce no `ack_valid` and no read result.
- R11: Step mode (0010) acknowledges the command. Until the stop, each `step_up` pulse raises the selected position by one, saturating at 63. Each `step_dn` pulse lowers it by one, saturating at 0. Other channels do not move, and pulses outside step mode do nothing.
- R12: `pos_out` shows channel c's position in bits [6c+5:6c] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (models power-up recall) |
| frame_open | input | 1 | Pulse: start plus matching address seen, next byte is a command |
| bus_stop | input | 1 | Pulse: stop condition seen, frame ends |
| in_valid | input | 1 | Incoming byte valid |
| in_ready | output | 1 | Block can take an incoming byte |
| in_data | input | 8 | Incoming byte |
| ack_valid | output | 1 | One-cycle pulse answering a taken byte |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Front end takes the read result |
| rd_data | output | 8 | Read result, upper two bits zero |
| step_up | input | 1 | Pulse: step selected wiper up |
| step_dn | input | 1 | Pulse: step selected wiper down |
| wp_n | input | 1 | Write protect, low blocks stored writes |
| busy | output | 1 | Nonvolatile write in progress |
| step_active | output | 1 | Step mode in effect |
| pos_out | output | 24 | All four wiper positions |

## Verification
The assertions assume the front end never raises `frame_open` and `bus_stop` in the same cycle. They also assume it offers no bytes between a stop and the next `frame_open`, except when the point is to show that such bytes vanish. The read-hold property assumes `rd_ready` is only sampled while a result is pending. The stimulus drives each pulse for exactly one cycle at the falling clock edge and never raises `step_up` and `step_dn` together. During `busy` it sends bytes only in the single R10 scenario, which expects them to be dropped.

// File: rtl/pot_exec_pkg.sv
package pot_exec_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int REG_W  = 2;
  localparam int CH_W   = 2;
  localparam int NCH    = 1 << CH_W;
  localparam int NREG   = 1 << REG_W;

  typedef enum logic [3:0] {
    K_NONE, K_RD_POS, K_WR_POS, K_RD_ST, K_WR_ST,
    K_S2P, K_P2S, K_GS2P, K_GP2S, K_STEP
  } act_e;

  typedef struct packed {
    act_e             kind;
    logic [REG_W-1:0] reg_sel;
    logic [CH_W-1:0]  ch;
  } cmd_t;

  typedef enum logic [2:0] {
    F_IDLE, F_CMD, F_DATA, F_READ, F_STEP, F_DRAIN
  } fstate_e;
endpackage

// File: rtl/pot_cmd_decode.sv
module pot_cmd_decode
  import pot_exec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output cmd_t              cmd
);
  logic [OP_W-1:0] op;
  logic            ch_zero;

  assign op      = byte_in[BYTE_W-1 -: OP_W];
  assign ch_zero = (byte_in[CH_W-1:0] == '0);

  always_comb begin
    cmd.reg_sel = byte_in[CH_W +: REG_W];
    cmd.ch      = byte_in[CH_W-1:0];
    unique case (op)
      4'b1001: cmd.kind = K_RD_POS;
      4'b1010: cmd.kind = K_WR_POS;
      4'b1011: cmd.kind = K_RD_ST;
      4'b1100: cmd.kind = K_WR_ST;
      4'b1101: cmd.kind = K_S2P;
      4'b1110: cmd.kind = K_P2S;
      4'b0001: cmd.kind = ch_zero ? K_GS2P : K_NONE;
      4'b1000: cmd.kind = ch_zero ? K_GP2S : K_NONE;
      4'b0010: cmd.kind = K_STEP;
      default: cmd.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/pot_wiper_bank.sv
module pot_wiper_bank
  import pot_exec_pkg::*;
#(
  parameter int           W         = 6,
  parameter logic [W-1:0] RESET_VAL = 6'h20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           load_mask,
  input  logic [NCH-1:0][W-1:0]    load_val,
  input  logic                     step_en,
  input  logic [CH_W-1:0]          step_ch,
  input  logic                     step_up,
  input  logic                     step_dn,
  output logic [NCH-1:0][W-1:0]    pos
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] pos_q;
    logic         mine;
    assign mine = step_en && (step_ch == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q <= RESET_VAL;
      end else if (load_mask[c]) begin
        pos_q <= load_val[c];
      end else if (mine && step_up && !step_dn && pos_q != TOP) begin
        pos_q <= pos_q + 1'b1;
      end else if (mine && step_dn && !step_up && pos_q != BOT) begin
        pos_q <= pos_q - 1'b1;
      end
    end
    assign pos[c] = pos_q;
  end
endmodule

// File: rtl/pot_store_bank.sv
module pot_store_bank
  import pot_exec_pkg::*;
#(
  parameter int           W         = 6,
  parameter logic [W-1:0] RESET_VAL = 6'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         commit_mask,
  input  logic [REG_W-1:0]       commit_reg,
  input  logic [NCH-1:0][W-1:0]  commit_val,
  input  logic [CH_W-1:0]        rd_ch,
  input  logic [REG_W-1:0]       rd_reg,
  output logic [W-1:0]           rd_val,
  output logic [NCH-1:0][W-1:0]  row_val
);
  logic [NCH-1:0][NREG-1:0][W-1:0] cells;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cell_q <= RESET_VAL;
        else if (commit_mask[c] && commit_reg == REG_W'(r))
          cell_q <= commit_val[c];
      end
      assign cells[c][r] = cell_q;
    end
    assign row_val[c] = cells[c][rd_reg];
  end

  assign rd_val = cells[rd_ch][rd_reg];
endmodule

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start && !busy)  cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/pot_exec.sv
module pot_exec
  import pot_exec_pkg::*;
#(
  parameter int           W           = 6,
  parameter int           BUSY_CYCLES = 5000,
  parameter logic [W-1:0] RESET_VAL   = 6'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_open,
  input  logic                bus_stop,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                ack_valid,
  output logic                ack_ok,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                step_up,
  input  logic                step_dn,
  input  logic                wp_n,
  output logic                busy,
  output logic                step_active,
  output logic [NCH*W-1:0]    pos_out
);
  localparam int PAD = BYTE_W - W;

  fstate_e               fstate;
  cmd_t                  cur, dec;
  logic [NCH-1:0]        pend_mask;
  logic [REG_W-1:0]      pend_reg;
  logic [NCH-1:0][W-1:0] pend_val;

  logic                  accept, frame_go, nv_done;
  logic [NCH-1:0]        ld_mask;
  logic [NCH-1:0][W-1:0] ld_val, pos, row_val;
  logic [W-1:0]          st_val;

  assign in_ready    = (fstate != F_READ);
  assign accept      = in_valid && in_ready;
  assign step_active = (fstate == F_STEP);
  assign pos_out     = pos;

  pot_cmd_decode u_dec (.byte_in(in_data), .cmd(dec));

  always_comb begin
    ld_mask = '0;
    ld_val  = '0;
    frame_go = frame_open && !busy;
    if (accept && !bus_stop && !frame_go) begin
      if (fstate == F_CMD && dec.kind == K_S2P) begin
        ld_mask[dec.ch] = 1'b1;
        ld_val[dec.ch]  = st_val;
      end else if (fstate == F_CMD && dec.kind == K_GS2P) begin
        ld_mask = '1;
        ld_val  = row_val;
      end else if (fstate == F_DATA && cur.kind == K_WR_POS) begin
        ld_mask[cur.ch] = 1'b1;
        ld_val[cur.ch]  = in_data[W-1:0];
      end
    end
  end

  pot_wiper_bank #(.W(W), .RESET_VAL(RESET_VAL)) u_wiper (
    .clk(clk), .rst_n(rst_n),
    .load_mask(ld_mask), .load_val(ld_val),
    .step_en(fstate == F_STEP), .step_ch(cur.ch),
    .step_up(step_up), .step_dn(step_dn),
    .pos(pos)
  );

  pot_store_bank #(.W(W), .RESET_VAL(RESET_VAL)) u_store (
    .clk(clk), .rst_n(rst_n),
    .commit_mask(nv_done ? pend_mask : '0),
    .commit_reg(pend_reg), .commit_val(pend_val),
    .rd_ch(dec.ch), .rd_reg(dec.reg_sel),
    .rd_val(st_val), .row_val(row_val)
  );

  pot_nv_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(bus_stop && pend_mask != '0),
    .busy(busy), .done(nv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstate    <= F_IDLE;
      cur       <= '0;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      pend_mask <= '0;
      pend_reg  <= '0;
      pend_val  <= '0;
    end else begin
      ack_valid <= 1'b0;
      if (nv_done) pend_mask <= '0;

      if (bus_stop) begin
        fstate   <= F_IDLE;
        rd_valid <= 1'b0;
      end else if (frame_go) begin
        fstate   <= F_CMD;
        rd_valid <= 1'b0;
      end else if (fstate == F_READ) begin
        if (rd_ready) begin
          rd_valid <= 1'b0;
          fstate   <= F_DRAIN;
        end
      end else if (accept) begin
        unique case (fstate)
          F_CMD: begin
            ack_valid <= 1'b1;
            ack_ok    <= (dec.kind != K_NONE);
            cur       <= dec;
            fstate    <= F_DRAIN;
            unique case (dec.kind)
              K_RD_POS: begin
                rd_valid <= 1'b1;
                rd_data  <= {{PAD{1'b0}}, pos[dec.ch]};
                fstate   <= F_READ;
              end
              K_RD_ST: begin
                rd_valid <= 1'b1;
                rd_data  <= {{PAD{1'b0}}, st_val};
                fstate   <= F_READ;
              end
              K_WR_POS, K_WR_ST: fstate <= F_DATA;
              K_STEP:            fstate <= F_STEP;
              K_P2S: if (wp_n) begin
                pend_mask          <= '0;
                pend_mask[dec.ch]  <= 1'b1;
                pend_reg           <= dec.reg_sel;
                pend_val[dec.ch]   <= pos[dec.ch];
              end
              K_GP2S: if (wp_n) begin
                pend_mask <= '1;
                pend_reg  <= dec.reg_sel;
                pend_val  <= pos;
              end
              default: ;
            endcase
          end
          F_DATA: begin
            ack_valid <= 1'b1;
            ack_ok    <= 1'b1;
            fstate    <= F_DRAIN;
            if (cur.kind == K_WR_ST && wp_n) begin
              pend_mask          <= '0;
              pend_mask[cur.ch]  <= 1'b1;
              pend_reg           <= cur.reg_sel;
              pend_val[cur.ch]   <= in_data[W-1:0];
            end
          end
          F_STEP, F_DRAIN: begin
            ack_valid <= 1'b1;
            ack_ok    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pot_exec_chk.sv
module pot_exec_chk #(
  parameter int BUSY_CYCLES = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_stop,
  input logic       busy,
  input logic       in_ready,
  input logic       ack_valid,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  int bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  // R4: busy window length
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == BUSY_CYCLES);
  p_busy_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < BUSY_CYCLES);
  // R4: busy only begins after a stop
  p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));
  // R3: read result held until taken, input stalled meanwhile
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  p_rd_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !in_ready);
  p_rd_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[7:6] == 2'b00);
  // R10: nothing answered during a busy window
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !ack_valid && !rd_valid);
endmodule

bind pot_exec pot_exec_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .busy(busy),
  .in_ready(in_ready), .ack_valid(ack_valid), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/tb_pot_exec.sv
module tb_pot_exec;
  localparam int CLK_PERIOD = 10;
  localparam int BUSYN = 20;

  logic clk = 0, rst_n = 0;
  logic frame_open = 0, bus_stop = 0, in_valid = 0, rd_ready = 0;
  logic step_up = 0, step_dn = 0, wp_n = 1;
  logic [7:0] in_data = 0;
  logic in_ready, ack_valid, ack_ok, rd_valid, busy, step_active;
  logic [7:0] rd_data;
  logic [23:0] pos_out;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pot_exec #(.BUSY_CYCLES(BUSYN)) dut (
    .clk(clk), .rst_n(rst_n), .frame_open(frame_open), .bus_stop(bus_stop),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .step_up(step_up),
    .step_dn(step_dn), .wp_n(wp_n), .busy(busy),
    .step_active(step_active), .pos_out(pos_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic open_f();
    frame_open = 1; @(negedge clk); frame_open = 0;
  endtask
  task automatic stop_f();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic send(input logic [7:0] b, input int exp_ok, input string tag);
    in_valid = 1; in_data = b; @(negedge clk); in_valid = 0;
    if (exp_ok < 0) chk({tag, " no ack pulse"}, ack_valid, 0);
    else begin
      chk({tag, " ack pulse"}, ack_valid, 1);
      chk({tag, " ack value"}, ack_ok, exp_ok);
    end
  endtask
  task automatic take_rd(input int exp, input string tag);
    chk({tag, " rd_valid"}, rd_valid, 1);
    @(negedge clk); @(negedge clk);
    chk({tag, " held valid"}, rd_valid, 1);
    chk({tag, " in stalled"}, in_ready, 0);
    chk({tag, " data"}, rd_data, exp);
    rd_ready = 1; @(negedge clk); rd_ready = 0;
    chk({tag, " taken"}, rd_valid, 0);
  endtask
  function automatic int posv(input int c);
    return int'(pos_out[c*6 +: 6]);
  endfunction
  task automatic rd_st(input int c, input int r, input int exp, input string tag);
    open_f(); send({4'b1011, 2'(r), 2'(c)}, 1, tag); take_rd(exp, tag); stop_f();
    chk({tag, " read starts no busy"}, busy, 0);
  endtask
  task automatic wr_pos(input int c, input logic [7:0] v, input string tag);
    open_f(); send({4'b1010, 2'b00, 2'(c)}, 1, tag); send(v, 1, tag); stop_f();
  endtask
  task automatic wait_busy(input string tag);
    int n = 0;
    chk({tag, " busy after stop"}, busy, 1);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk({tag, " busy length"}, n, BUSYN);
  endtask
  task automatic no_busy(input string tag);
    @(negedge clk); chk({tag, " no busy"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    for (int c = 0; c < 4; c++) chk("R1 R12 pos", posv(c), 'h20);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) rd_st(c, r, 'h20, "R1 stored");
  endtask

  task automatic t_write_pos();
    wr_pos(2, 8'hC5, "R2 wr pos");
    chk("R2 R12 pos2 low bits", posv(2), 'h05);
    chk("R12 pos1 untouched", posv(1), 'h20);
    open_f(); send(8'b1001_00_10, 1, "R3 rd pos"); take_rd('h05, "R3 rd pos"); stop_f();
  endtask

  task automatic t_write_stored();
    open_f(); send(8'b1100_10_01, 1, "R4 wr st"); send(8'h7A, 1, "R4 data");
    @(negedge clk); chk("R4 no busy before stop", busy, 0);
    stop_f(); wait_busy("R4");
    rd_st(1, 2, 'h3A, "R4 stored after window");
    rd_st(1, 1, 'h20, "R4 neighbour unchanged");
  endtask

  task automatic t_copy_s2p();
    open_f(); send(8'b1101_10_01, 1, "R5 s2p");
    chk("R5 pos1 loaded", posv(1), 'h3A);
    stop_f(); no_busy("R5");
  endtask

  task automatic t_copy_p2s();
    wr_pos(3, 8'h11, "R6 setup");
    open_f(); send(8'b1110_11_11, 1, "R6 p2s"); stop_f();
    wait_busy("R6");
    rd_st(3, 3, 'h11, "R6 stored");
  endtask

  task automatic t_global();
    for (int c = 0; c < 4; c++) wr_pos(c, 8'(c + 1), "R7 setup");
    open_f(); send(8'b1000_01_00, 1, "R7 gp2s"); stop_f(); wait_busy("R7");
    for (int c = 0; c < 4; c++) rd_st(c, 1, c + 1, "R7 gp2s stored");
    for (int c = 0; c < 4; c++) wr_pos(c, 8'h3F, "R7 setup2");
    open_f(); send(8'b0001_01_01, 0, "R7 bad channel bits"); stop_f();
    chk("R7 bad global no change", posv(1), 'h3F);
    open_f(); send(8'b0001_01_00, 1, "R7 gs2p");
    for (int c = 0; c < 4; c++) chk("R7 gs2p pos", posv(c), c + 1);
    stop_f(); no_busy("R7 gs2p");
  endtask

  task automatic t_protect();
    wp_n = 0;
    open_f(); send(8'b1100_11_00, 1, "R8 wr st"); send(8'h2A, 1, "R8 data");
    stop_f(); no_busy("R8 wr");
    open_f(); send(8'b1110_11_00, 1, "R8 p2s"); stop_f(); no_busy("R8 p2s");
    open_f(); send(8'b1000_11_00, 1, "R8 gp2s"); stop_f(); no_busy("R8 gp2s");
    wp_n = 1;
    rd_st(0, 3, 'h20, "R8 stored kept");
    rd_st(2, 3, 'h20, "R8 global kept");
  endtask

  task automatic t_undef();
    open_f(); send(8'b0000_00_00, 0, "R9 op0000"); send(8'h15, 0, "R9 drain"); stop_f();
    open_f(); send(8'b0011_00_01, 0, "R9 op0011"); stop_f();
    open_f(); send(8'b1111_01_10, 0, "R9 op1111"); stop_f();
    no_busy("R9");
    chk("R9 pos0", posv(0), 1);
    chk("R9 pos1", posv(1), 2);
  endtask

  task automatic t_busy();
    open_f(); send(8'b1100_00_10, 1, "R10 wr"); send(8'h15, 1, "R10 data"); stop_f();
    open_f();
    send(8'b1001_00_00, -1, "R10 byte during busy");
    chk("R10 no read", rd_valid, 0);
    while (busy) @(negedge clk);
    rd_st(2, 0, 'h15, "R10 commit");
  endtask

  task automatic t_step();
    wr_pos(0, 8'h3E, "R11 setup");
    step_up = 1; @(negedge clk); step_up = 0;
    chk("R11 pulse outside step mode", posv(0), 'h3E);
    open_f(); send(8'b0010_00_00, 1, "R11 enter");
    chk("R11 active", step_active, 1);
    for (int i = 0; i < 3; i++) begin step_up = 1; @(negedge clk); step_up = 0; @(negedge clk); end
    chk("R11 saturate top", posv(0), 'h3F);
    chk("R11 other channel", posv(1), 2);
    for (int i = 0; i < 3; i++) begin step_dn = 1; @(negedge clk); step_dn = 0; end
    chk("R11 down", posv(0), 'h3C);
    stop_f();
    wr_pos(0, 8'h01, "R11 setup2");
    open_f(); send(8'b0010_00_00, 1, "R11 enter2");
    for (int i = 0; i < 3; i++) begin step_dn = 1; @(negedge clk); step_dn = 0; end
    chk("R11 saturate bottom", posv(0), 0);
    stop_f();
    chk("R11 left", step_active, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_pos();
    t_write_stored();
    t_copy_s2p();
    t_copy_p2s();
    t_global();
    t_protect();
    t_undef();
    t_busy();
    t_step();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule